// File: doc/BRIEF.md
# Programmable External Interrupt Controller

This block collects a parameterised number of external interrupt pins (up to 32) and folds them into a single interrupt request for a processor. Each pin passes through a two-stage synchroniser. The block then checks the pin for the event its line is programmed to watch for. Edge-sensing lines watch for a rising or a falling transition. Level-sensing lines watch for a high or a low level.

A detected event sets a per-line flag. The flags are ANDed with a per-line arm (mask) vector, and the OR of the result is registered onto the request output.

Software reaches the controller through a small synchronous register port. The port has one write strobe and a word address, and read data is registered.

- The arm vector is changed only through separate set and clear strobe registers.
- Flags are cleared by writing ones to a clear register.
- The three sense-configuration registers are read/write, so read-modify-write updates are safe.
- Only implemented lines own storage. Writing all ones to a configuration register and reading it back shows how many lines exist.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the arm vector, the flags, the three sense-configuration registers and `irq_out` are all zero, so every line is disarmed and senses a falling edge.
- R2: The sense-kind (address 3), edge-direction (address 4) and level-polarity (address 5) registers read back what was written, one bit per line in bit i for line i. Bits at or above N_LINES read as zero, so writing 0xFFFFFFFF reads back as 2^N_LINES-1.
- R3: Each 1 written to the arm-set register (address 0) arms that line, and each 1 written to arm-clear (address 1) disarms it. Bits written as 0 change nothing, and the arm vector reads at address 2.
- R4: With sense-kind bit 0 and edge-direction bit 1, a 0-to-1 transition on the synchronised pin sets that line's flag, and a 1-to-0 transition does not.
- R5: With sense-kind bit 0 and edge-direction bit 0, a 1-to-0 transition sets the flag, and a 0-to-1 transition does not.
- R6: With sense-kind bit 1, the flag is set whenever the pin equals the level-polarity bit (1 active-high, 0 active-low). A clear while the level is still active leaves the flag set.
- R7: Flags read at address 6. A flag set by an edge stays set until a 1 is written to its bit of the flag-clear register (address 7). Zero bits of that write leave their flags alone.
- R8: `irq_out` is registered and equals the OR over lines of flag AND arm as it stood one cycle earlier. It therefore drops in the cycle after the last pending line is cleared or disarmed.
- R9: Flags latch events on disarmed lines too, without raising `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pins | input | N_LINES | Asynchronous external interrupt pins |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The properties assume that the register port addresses only one register per cycle. Under that assumption an arm-set and an arm-clear never coincide, and a flag can fall only in the cycle after a flag-clear write that named it. The bench drives its bus writes one at a time, at the falling clock edge.

The bench holds each pin level long enough to pass the synchroniser before it changes the level again. It clears all flags after every reconfiguration, so edges caused by the mode change itself never leak into a check.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RS_ARM_SET  = 3'd0,
    RS_ARM_CLR  = 3'd1,
    RS_ARM      = 3'd2,
    RS_SENSE    = 3'd3,
    RS_EDGE_DIR = 3'd4,
    RS_LVL_POL  = 3'd5,
    RS_FLAG     = 3'd6,
    RS_FLAG_CLR = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pin_async;
      stage2_q <= stage1_q;
    end
  end

  assign pin_sync = stage2_q;
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] sense_lvl,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] lvl_high,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flag
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise_w;
    logic fall_w;
    assign rise_w = pin_sync[i] & ~prev_q[i];
    assign fall_w = ~pin_sync[i] & prev_q[i];
    always_comb begin
      if (sense_lvl[i])
        hit[i] = lvl_high[i] ? pin_sync[i] : ~pin_sync[i];
      else
        hit[i] = edge_rise[i] ? rise_w : fall_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= pin_sync;
      flag_q <= hit | (flag_q & ~clr_mask);
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      flag,
  output logic [W-1:0]      arm,
  output logic [W-1:0]      sense_lvl,
  output logic [W-1:0]      edge_rise,
  output logic [W-1:0]      lvl_high,
  output logic [W-1:0]      clr_mask,
  output logic [DATA_W-1:0] rdata
);
  logic [W-1:0] wbits;
  logic [W-1:0] arm_q, sense_q, edge_q, lvl_q;
  logic [W-1:0] rsel;

  assign wbits = wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= '0;
      sense_q <= '0;
      edge_q  <= '0;
      lvl_q   <= '0;
    end else if (we) begin
      unique case (reg_sel_e'(addr))
        RS_ARM_SET:  arm_q   <= arm_q | wbits;
        RS_ARM_CLR:  arm_q   <= arm_q & ~wbits;
        RS_SENSE:    sense_q <= wbits;
        RS_EDGE_DIR: edge_q  <= wbits;
        RS_LVL_POL:  lvl_q   <= wbits;
        default: ;
      endcase
    end
  end

  assign clr_mask = (we && reg_sel_e'(addr) == RS_FLAG_CLR) ? wbits : '0;

  always_comb begin
    unique case (reg_sel_e'(addr))
      RS_ARM:      rsel = arm_q;
      RS_SENSE:    rsel = sense_q;
      RS_EDGE_DIR: rsel = edge_q;
      RS_LVL_POL:  rsel = lvl_q;
      RS_FLAG:     rsel = flag;
      default:     rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata        <= '0;
      rdata[W-1:0] <= rsel;
    end
  end

  assign arm       = arm_q;
  assign sense_lvl = sense_q;
  assign edge_rise = edge_q;
  assign lvl_high  = lvl_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_LINES-1:0] pins,
  output logic              irq_out
);
  logic [N_LINES-1:0] pin_sync;
  logic [N_LINES-1:0] arm_q, flag_q;
  logic [N_LINES-1:0] sense_lvl, edge_rise, lvl_high, clr_mask;
  logic               irq_q;

  extirq_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pins), .pin_sync(pin_sync)
  );

  extirq_detect #(.W(N_LINES)) u_detect (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .sense_lvl(sense_lvl),
    .edge_rise(edge_rise), .lvl_high(lvl_high), .clr_mask(clr_mask),
    .flag(flag_q)
  );

  extirq_regs #(.W(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .flag(flag_q), .arm(arm_q), .sense_lvl(sense_lvl), .edge_rise(edge_rise),
    .lvl_high(lvl_high), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & arm_q);
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
  import extirq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [N_LINES-1:0] arm,
  input logic [N_LINES-1:0] flag,
  input logic               irq_out
);
  logic [N_LINES-1:0] wr_bits;
  logic               wr_set, wr_clr;
  logic [N_LINES-1:0] clr_bits;

  assign wr_bits  = bus_wdata[N_LINES-1:0];
  assign wr_set   = bus_we && bus_addr == RS_ARM_SET;
  assign wr_clr   = bus_we && bus_addr == RS_ARM_CLR;
  assign clr_bits = (bus_we && bus_addr == RS_FLAG_CLR) ? wr_bits : '0;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $fell(rst) |-> (arm == '0 && flag == '0 && irq_out == 1'b0)); // R1

  AST_ARM_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((arm & $past(wr_bits)) == $past(wr_bits)
                && (arm & ~$past(wr_bits)) == ($past(arm) & ~$past(wr_bits)))); // R3

  AST_ARM_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((arm & $past(wr_bits)) == '0
                && (arm & ~$past(wr_bits)) == ($past(arm) & ~$past(wr_bits)))); // R3

  AST_ARM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_set && !wr_clr) |=> $stable(arm)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flag) & ~flag & ~$past(clr_bits)) == '0)); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == |($past(flag) & $past(arm)))); // R8
endmodule

bind extirq_ctrl extirq_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .arm(arm_q), .flag(flag_q), .irq_out(irq_out)
);

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
  localparam int N = 8;
  localparam logic [31:0] ALL = (32'd1 << N) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pins = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  extirq_ctrl #(.N_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(pins), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    rd(3'd2, rv); chk("R1 arm", rv, 0);
    rd(3'd6, rv); chk("R1 flag", rv, 0);
    rd(3'd3, rv); chk("R1 sense", rv, 0);
    rd(3'd4, rv); chk("R1 edge", rv, 0);
    rd(3'd5, rv); chk("R1 lvl", rv, 0);

    // R2 readback and line discovery
    for (int a = 3; a <= 5; a++) begin
      wr(a[2:0], 32'hFFFF_FFFF); rd(a[2:0], rv); chk("R2 all-ones", rv, ALL);
      wr(a[2:0], 32'h5A5A_5AA5); rd(a[2:0], rv); chk("R2 pattern", rv, 32'h5A5A_5AA5 & ALL);
      wr(a[2:0], 32'h0);
    end

    // R3 arm set/clear strobes
    wr(3'd0, 32'h0F); rd(3'd2, rv); chk("R3 set", rv, 32'h0F);
    wr(3'd0, 32'h30); rd(3'd2, rv); chk("R3 set more", rv, 32'h3F);
    wr(3'd1, 32'h05); rd(3'd2, rv); chk("R3 clr", rv, 32'h3A);
    wr(3'd1, 32'h00); rd(3'd2, rv); chk("R3 clr zero", rv, 32'h3A);
    wr(3'd0, 32'h00); rd(3'd2, rv); chk("R3 set zero", rv, 32'h3A);
    wr(3'd1, 32'hFF);

    // Sweep: mode m 0 falling,1 rising,2 low level,3 high level; every line
    for (int m = 0; m < 4; m++) begin
      logic [N-1:0] idle_v;
      string tag;
      idle_v = (m == 0 || m == 2) ? '1 : '0;
      tag = (m == 0) ? "R5" : (m == 1) ? "R4" : "R6";
      wr(3'd3, (m >= 2) ? ALL : 32'd0);
      wr(3'd4, (m == 1) ? ALL : 32'd0);
      wr(3'd5, (m == 3) ? ALL : 32'd0);
      for (int i = 0; i < N; i++) begin
        @(negedge clk); pins = idle_v;
        idle(5);
        wr(3'd7, ALL);
        rd(3'd6, rv); chk({tag, " quiet"}, rv, 0);
        @(negedge clk); pins = idle_v ^ (N'(1) << i);
        idle(5);
        rd(3'd6, rv); chk({tag, " hit"}, rv, 32'd1 << i);
        idle(3);
        rd(3'd6, rv); chk({tag, " held R7"}, rv, 32'd1 << i);
        wr(3'd7, 32'd0);
        rd(3'd6, rv); chk("R7 zero clear", rv, 32'd1 << i);
        wr(3'd7, 32'd1 << i);
        idle(2);
        rd(3'd6, rv);
        if (m >= 2) chk("R6 reassert", rv, 32'd1 << i);
        else        chk("R7 cleared", rv, 0);
        @(negedge clk); pins = idle_v;
        idle(5);
        wr(3'd7, (m >= 2) ? ALL : 32'd0);
        rd(3'd6, rv); chk({tag, " opposite/inactive"}, rv, 0);
      end
    end

    // R8/R9 combined output timing, falling edge on line 2
    wr(3'd3, 0); wr(3'd4, 0); wr(3'd5, 0);
    @(negedge clk); pins = '1;
    idle(5); wr(3'd7, ALL); wr(3'd1, ALL);
    @(negedge clk); pins = 8'hFB;
    idle(6);
    chk("R9 no irq when disarmed", {31'd0, irq_out}, 0);
    rd(3'd6, rv); chk("R9 flag latched", rv, 32'h04);
    wr(3'd0, 32'h04);
    chk("R8 irq one cycle later", {31'd0, irq_out}, 0);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irq_out}, 1);
    wr(3'd1, 32'h04);
    chk("R8 irq registered hold", {31'd0, irq_out}, 1);
    @(negedge clk);
    chk("R8 irq drop on disarm", {31'd0, irq_out}, 0);
    wr(3'd0, 32'h04);
    idle(1);
    chk("R8 irq rearmed", {31'd0, irq_out}, 1);
    wr(3'd7, 32'h04);
    chk("R8 irq hold after clear", {31'd0, irq_out}, 1);
    @(negedge clk);
    chk("R8 irq drop on clear", {31'd0, irq_out}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule